// File: doc/BRIEF.md
# External Data Space Access Router

This block sits between a CPU core and the data-space targets reached through move-to/from-external instructions. Each request arrives either as a 16-bit pointer access or as an 8-bit register-indirect access. For the 8-bit form, a page register holds the upper address byte. The block forms the effective address and compares it against an on-chip window at the top of the address space. It then steers the access to the on-chip data memory or peripheral window, or to the external multiplexed bus.

Two control bits set the routing. The first is a sticky disable bit. It comes out of reset set, so every access goes to the external bus. Software can clear it once, and only a reset sets it again. The second is a visibility bit: when it is set, on-chip accesses are also shown on the external bus strobes. A pin that selects internal program execution must be high for on-chip routing to happen at all. Both registers sit on a small special-function-register port that uses address compare.

On-chip reads return registered data one cycle after the request. External accesses hold `busy` until the bus side acknowledges.

Top module: `xds_router`

## Requirements
- R1: After reset, the control register reads 8'hFD. Bit 0 is the disable bit (1 = on-chip routing off), bit 1 is the visibility bit (0), and bits 7:2 read as 1. The page register reads 8'h00.
- R2: A valid request targets on-chip memory when all three of these hold: the pin `intCodeEn` is 1, the disable bit is 0, and the effective address is at or above 16'hF700. In that case `onchipSel` is 1 and `onchipAddr` equals the effective address. In every other case `onchipSel` is 0.
- R3: A control-register write clears the disable bit when write data bit 0 is 0. A later write of 1 to bit 0 leaves it at 0. Only reset sets it again.
- R4: For a register-indirect request (`reqWide` = 0), the effective address is {page register, `reqReg`}. For a pointer request (`reqWide` = 1), it is `reqPtr`. The window check is applied to this effective address in both cases.
- R5: With the visibility bit at 0, an on-chip request drives `extBusEn`, `extRdEn`, `extWrEn` and `visibleFlag` to 0.
- R6: With the visibility bit at 1, an on-chip request drives `extBusEn` to 1 and `visibleFlag` to 1. It also drives `extRdEn` (for a read) or `extWrEn` (for a write), with no wait state.
- R7: The visibility bit has no effect on a request outside the window or while the disable bit is 1. Such a request is external: `extBusEn` is 1, the strobe for its direction is 1, and `visibleFlag` is 0.
- R8: With `intCodeEn` at 0, every request goes to the external bus whatever the control bits hold.
- R9: An external request drives `busy` to 1 until the cycle in which `extAck` is 1. For a read, `cpuRdValid` is 1 in the following cycle and `cpuRdata` holds the `extRdata` value from the acknowledge cycle.
- R10: An on-chip read drives `cpuRdValid` to 1 in the next cycle, with `cpuRdata` equal to the `onchipRdata` value presented during the request cycle.
- R11: `extHiEn` (upper address byte driven on the bus) is 1 only when the bus is enabled for a pointer request. For register-indirect requests the upper port stays general I/O.
- R12: The page register is written and read at special-function-register address 8'h91, and the control register at 8'hB1. Reads at any other address return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| intCodeEn | input | 1 | Internal program execution pin; 0 forces all accesses external |
| sfrWe | input | 1 | Register write strobe |
| sfrAddr | input | 8 | Register address |
| sfrWdata | input | 8 | Register write data |
| sfrRdata | output | 8 | Register read data (combinational) |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit indirect |
| reqPtr | input | 16 | Pointer address |
| reqReg | input | 8 | Indirect register low address |
| reqWdata | input | 8 | Write data |
| onchipSel | output | 1 | On-chip memory select |
| onchipWe | output | 1 | On-chip memory write enable |
| onchipAddr | output | 16 | On-chip memory address |
| onchipWdata | output | 8 | On-chip memory write data |
| onchipRdata | input | 8 | On-chip memory read data |
| extBusEn | output | 1 | External bus drives address/data |
| extHiEn | output | 1 | Upper address byte driven on the bus |
| extRdEn | output | 1 | External read strobe enable |
| extWrEn | output | 1 | External write strobe enable |
| extAddr | output | 16 | External address |
| extWdata | output | 8 | External write data |
| extRdata | input | 8 | External read data |
| extAck | input | 1 | External bus completion |
| visibleFlag | output | 1 | On-chip access mirrored onto the bus |
| busy | output | 1 | CPU must hold its request |
| cpuRdValid | output | 1 | Read data valid |
| cpuRdata | output | 8 | Read data to CPU |

## Verification
The routing function is swept over every combination of pin level, visibility bit, access width and direction. Eight addresses are used, grouped around the window boundary (16'hF6FF, 16'hF700, 16'hF701) and covering the low, middle and top of the space. The sweep runs once with the disable bit set and once after it is cleared. The boundary pairs separate an off-by-one in the window compare. The width split separates the page register path from the pointer path. The two disable phases together with the pin sweep show whether each gating term acts alone. Directed sequences cover the sticky clear, the wait for acknowledge, and the registered read return.

// File: rtl/xds_pkg.sv
package xds_pkg;
  // strobes sent from control to datapath
  typedef struct packed {
    logic pageWe;     // load page register
    logic capOnchip;  // capture on-chip read data
    logic capExt;     // capture external read data
  } dpStrobe_t;
endpackage

// File: rtl/xds_datapath.sv
module xds_datapath
  import xds_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hF700,
  parameter logic [7:0] CTRL_SFR = 8'hB1,
  parameter logic [7:0] PAGE_SFR = 8'h91
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  input  logic              mapOff,
  input  logic              visOn,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqPtr,
  input  logic [DATA_W-1:0] reqReg,
  input  logic [DATA_W-1:0] onchipRdata,
  input  logic [DATA_W-1:0] extRdata,
  input  dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] effAddr,
  output logic              inWin,
  output logic [DATA_W-1:0] sfrRdata,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int PAGE_W = ADDR_W - DATA_W;

  logic [PAGE_W-1:0] pageReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageReg <= '0;
    else if (strobe.pageWe) pageReg <= sfrWdata[PAGE_W-1:0];
  end

  always_comb begin
    effAddr = reqWide ? reqPtr : {pageReg, reqReg};
    inWin   = (effAddr >= WIN_BASE);
  end

  always_comb begin
    if (sfrAddr == CTRL_SFR)      sfrRdata = {{(DATA_W-2){1'b1}}, visOn, mapOff};
    else if (sfrAddr == PAGE_SFR) sfrRdata = DATA_W'(pageReg);
    else                          sfrRdata = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuRdata <= '0;
    else if (strobe.capOnchip) cpuRdata <= onchipRdata;
    else if (strobe.capExt)    cpuRdata <= extRdata;
  end

  // R10/R9: the two capture sources never coincide
  p_one_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capOnchip && strobe.capExt));
  // R4: a narrow access never reaches the window through a page below it
  p_narrow_page_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!reqWide && pageReg < WIN_BASE[ADDR_W-1:DATA_W]) |-> !inWin);
endmodule

// File: rtl/xds_ctrl.sv
module xds_ctrl
  import xds_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [7:0] CTRL_SFR = 8'hB1,
  parameter logic [7:0] PAGE_SFR = 8'h91
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intCodeEn,
  input  logic              sfrWe,
  input  logic [7:0]        sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic              inWin,
  input  logic              extAck,
  output logic              mapOff,
  output logic              visOn,
  output logic              onchipSel,
  output logic              onchipWe,
  output logic              extBusEn,
  output logic              extHiEn,
  output logic              extRdEn,
  output logic              extWrEn,
  output logic              visibleFlag,
  output logic              busy,
  output logic              cpuRdValid,
  output dpStrobe_t         strobe
);
  logic ctrlWe;
  logic toChip;

  assign ctrlWe = sfrWe && (sfrAddr == CTRL_SFR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapOff <= 1'b1;
      visOn  <= 1'b0;
    end else if (ctrlWe) begin
      mapOff <= mapOff & sfrWdata[0];
      visOn  <= sfrWdata[1];
    end
  end

  always_comb begin
    toChip      = intCodeEn && !mapOff && inWin;
    onchipSel   = reqValid && toChip;
    onchipWe    = onchipSel && reqWrite;
    extBusEn    = reqValid && (!toChip || visOn);
    extHiEn     = extBusEn && reqWide;
    extRdEn     = extBusEn && !reqWrite;
    extWrEn     = extBusEn && reqWrite;
    visibleFlag = onchipSel && visOn;
    busy        = reqValid && !toChip && !extAck;
    strobe.pageWe    = sfrWe && (sfrAddr == PAGE_SFR);
    strobe.capOnchip = onchipSel && !reqWrite;
    strobe.capExt    = reqValid && !toChip && !reqWrite && extAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuRdValid <= 1'b0;
    else       cpuRdValid <= strobe.capOnchip || strobe.capExt;
  end

  p_sticky_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(mapOff));
  p_pin_forces_ext_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !intCodeEn) |-> (!onchipSel && extBusEn));
  p_hidden_strobes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (onchipSel && !visOn) |-> (!extRdEn && !extWrEn && !extBusEn));
  p_mirror_nowait_r6: assert property (@(posedge clk) disable iff (!rstN)
    onchipSel |-> !busy);
  p_outside_ext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !inWin) |-> (extBusEn && !visibleFlag));
  p_read_return_r10: assert property (@(posedge clk) disable iff (!rstN)
    (onchipSel && !reqWrite) |=> cpuRdValid);
  p_hi_byte_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqWide |-> !extHiEn);
endmodule

// File: rtl/xds_router.sv
module xds_router
  import xds_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hF700,
  parameter logic [7:0] CTRL_SFR = 8'hB1,
  parameter logic [7:0] PAGE_SFR = 8'h91
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intCodeEn,
  input  logic              sfrWe,
  input  logic [7:0]        sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic [DATA_W-1:0] sfrRdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqPtr,
  input  logic [DATA_W-1:0] reqReg,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              onchipSel,
  output logic              onchipWe,
  output logic [ADDR_W-1:0] onchipAddr,
  output logic [DATA_W-1:0] onchipWdata,
  input  logic [DATA_W-1:0] onchipRdata,
  output logic              extBusEn,
  output logic              extHiEn,
  output logic              extRdEn,
  output logic              extWrEn,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata,
  input  logic [DATA_W-1:0] extRdata,
  input  logic              extAck,
  output logic              visibleFlag,
  output logic              busy,
  output logic              cpuRdValid,
  output logic [DATA_W-1:0] cpuRdata
);
  dpStrobe_t         strobe;
  logic              mapOff, visOn, inWin;
  logic [ADDR_W-1:0] effAddr;

  xds_ctrl #(.DATA_W(DATA_W), .CTRL_SFR(CTRL_SFR), .PAGE_SFR(PAGE_SFR)) ctrl_i (
    .clk(clk), .rstN(rstN), .intCodeEn(intCodeEn),
    .sfrWe(sfrWe), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqWide(reqWide),
    .inWin(inWin), .extAck(extAck),
    .mapOff(mapOff), .visOn(visOn),
    .onchipSel(onchipSel), .onchipWe(onchipWe),
    .extBusEn(extBusEn), .extHiEn(extHiEn), .extRdEn(extRdEn), .extWrEn(extWrEn),
    .visibleFlag(visibleFlag), .busy(busy), .cpuRdValid(cpuRdValid),
    .strobe(strobe)
  );

  xds_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE),
                 .CTRL_SFR(CTRL_SFR), .PAGE_SFR(PAGE_SFR)) dp_i (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .mapOff(mapOff), .visOn(visOn),
    .reqWide(reqWide), .reqPtr(reqPtr), .reqReg(reqReg),
    .onchipRdata(onchipRdata), .extRdata(extRdata), .strobe(strobe),
    .effAddr(effAddr), .inWin(inWin), .sfrRdata(sfrRdata), .cpuRdata(cpuRdata)
  );

  assign onchipAddr  = effAddr;
  assign extAddr     = effAddr;
  assign onchipWdata = reqWdata;
  assign extWdata    = reqWdata;

  // R2: on-chip select only for addresses inside the window
  p_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    onchipSel |-> (onchipAddr >= WIN_BASE));
endmodule

// File: tb/xds_router_tb_top.sv
`timescale 1ns/1ps
module xds_router_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intCodeEn = 1'b1, sfrWe = 1'b0, reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0, extAck = 1'b0;
  logic [7:0] sfrAddr = '0, sfrWdata = '0, reqReg = '0, reqWdata = '0, onchipRdata = '0, extRdata = '0;
  logic [15:0] reqPtr = '0;
  logic [7:0] sfrRdata, cpuRdata, onchipWdata, extWdata;
  logic [15:0] onchipAddr, extAddr;
  logic onchipSel, onchipWe, extBusEn, extHiEn, extRdEn, extWrEn, visibleFlag, busy, cpuRdValid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xds_router dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfrWe = 1'b1; sfrAddr = a; sfrWdata = d;
    @(negedge clk); sfrWe = 1'b0;
  endtask

  task automatic sfrRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfrAddr = a; #1 d = sfrRdata;
  endtask

  function automatic logic [15:0] edgeAddr(input int k);
    case (k)
      0: return 16'h0000; 1: return 16'h1234; 2: return 16'h7F00; 3: return 16'hF6FF;
      4: return 16'hF700; 5: return 16'hF701; 6: return 16'hF800; default: return 16'hFFFF;
    endcase
  endfunction

  // expected routing computed from R2, R4-R8, R11
  task automatic sweep(input bit off, input string tag);
    logic [7:0] rd;
    for (int pin = 0; pin < 2; pin++)
      for (int vis = 0; vis < 2; vis++) begin
        sfrWrite(8'hB1, {6'b0, vis[0], off});
        sfrRead(8'hB1, rd);
        check("R12 ctrl readback", rd, {6'b111111, vis[0], off});
        for (int wide = 0; wide < 2; wide++)
          for (int wr = 0; wr < 2; wr++)
            for (int k = 0; k < 8; k++) begin
              logic [15:0] a;
              bit chip, bus;
              a = edgeAddr(k);
              if (!wide) sfrWrite(8'h91, a[15:8]);
              @(negedge clk);
              intCodeEn = pin[0]; reqValid = 1'b1; reqWide = wide[0]; reqWrite = wr[0];
              reqPtr = wide ? a : 16'h0000; reqReg = a[7:0];
              #1;
              chip = pin[0] && !off && (a >= 16'hF700);
              bus  = !chip || vis[0];
              check({tag, " R2/R4-R8/R11 routing"},
                    {onchipSel, onchipWe, extBusEn, extRdEn, extWrEn, visibleFlag, busy, extHiEn},
                    {chip, chip && wr[0], bus, bus && !wr[0], bus && wr[0], chip && vis[0], !chip, bus && wide[0]});
              check({tag, " R4 address"}, {onchipAddr, extAddr}, {a, a});
              @(negedge clk); reqValid = 1'b0;
            end
      end
    intCodeEn = 1'b1;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 idle outputs", {onchipSel, extBusEn, busy, cpuRdValid}, 4'b0);
    sfrRead(8'hB1, rd); check("R1 ctrl reset", rd, 8'hFD);
    sfrRead(8'h91, rd); check("R1 page reset", rd, 8'h00);
    sfrRead(8'h42, rd); check("R12 unmapped read", rd, 8'h00);
    sfrWrite(8'h91, 8'h5A);
    sfrRead(8'h91, rd); check("R12 page readback", rd, 8'h5A);

    sweep(1'b1, "off");
    // R3: clear, then try to set again
    sfrWrite(8'hB1, 8'h00);
    sfrRead(8'hB1, rd); check("R3 cleared", rd, 8'hFC);
    sfrWrite(8'hB1, 8'h01);
    sfrRead(8'hB1, rd); check("R3 set ignored", rd, 8'hFC);
    sweep(1'b0, "on");
    sfrWrite(8'hB1, 8'h01);
    sfrRead(8'hB1, rd); check("R3 still clear after sweep", rd, 8'hFC);

    // R10: on-chip read return
    @(negedge clk);
    reqValid = 1'b1; reqWide = 1'b1; reqWrite = 1'b0; reqPtr = 16'hF800; onchipRdata = 8'h3C;
    @(negedge clk); reqValid = 1'b0; onchipRdata = 8'h00; #1;
    check("R10 valid", cpuRdValid, 1'b1);
    check("R10 data", cpuRdata, 8'h3C);
    @(negedge clk); #1; check("R10 single pulse", cpuRdValid, 1'b0);

    // R9: external read waits for acknowledge
    @(negedge clk);
    reqValid = 1'b1; reqPtr = 16'h1000; extRdata = 8'hA5;
    for (int w = 0; w < 3; w++) begin
      #1; check("R9 busy while waiting", busy, 1'b1);
      @(negedge clk); #1; check("R9 no data before ack", cpuRdValid, 1'b0);
    end
    extAck = 1'b1; #1; check("R9 busy drops on ack", busy, 1'b0);
    @(negedge clk); reqValid = 1'b0; extAck = 1'b0; extRdata = 8'h00; #1;
    check("R9 valid after ack", cpuRdValid, 1'b1);
    check("R9 data", cpuRdata, 8'hA5);

    // R3: reset sets the disable bit again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    sfrRead(8'hB1, rd); check("R3 reset restores", rd, 8'hFD);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (100000) @(posedge clk);
        errors++; checks++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule